// File: doc/BRIEF.md
# SECDED Write Path with Byte Merge

This block sits between a local write port and a memory controller. It stores write data as SECDED codewords. The local data bus is split into 64-bit lanes, and each lane has its own encoder that produces a 72-bit codeword. A write with every byte enable set is encoded and sent to memory on the next cycle, with no read.

A write with any byte enable clear is a partial write. The block then reads the word at that address and checks each lane. It repairs a single flipped bit, keeps the stored bytes whose enables are clear, takes the new bytes whose enables are set, re-encodes every lane, and writes the full word back. While this read-merge-write sequence runs, the local port is not ready, so only one partial write is in flight at a time. If the read shows an error that cannot be corrected in a lane being merged, the write still completes and an error flag pulses with it.

When the ECC enable input is low, the block runs in bypass mode for controller testing. Data passes through unencoded, the check byte is zero, and byte enables are ignored.

Top module: `secded_write_merge`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_ready` is 1 and `mem_wr_valid`, `mem_rd_req` and `err_dbl` are 0.
- R2: A write accepted with `ecc_en`=1 and all byte enables set drives `mem_wr_valid` on the next cycle, with the same address and no read. Each lane carries a 72-bit codeword built as follows. Bits 1..71 are Hamming positions. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64. Data bits 0..63 fill the other positions in ascending order. The check bit at position 2^k is the XOR of the data positions whose index has bit k set. Bit 0 makes the parity of the whole codeword even.
- R3: Lanes are independent. Lane i uses `wr_data[64i+63:64i]`, `wr_be[8i+7:8i]` and memory bits `[72i+71:72i]`.
- R4: With `ecc_en`=0, an accepted write always produces a direct write on the next cycle, whatever the byte enables are. Each lane is `{8'h00, data}`, and no read is issued.
- R5: A write accepted with `ecc_en`=1 and any byte enable clear makes `mem_rd_req` high for exactly one cycle on the next cycle, with the write address. No write goes out on that cycle, and `wr_ready` stays 0 until the write-back.
- R6: On the cycle after `mem_rd_valid` during a read-merge-write, the block writes the merged word to the held address, and `wr_ready` returns to 1. Each lane holds the new bytes where the enable is set and the stored bytes where it is clear, re-encoded as in R2. A fully enabled lane takes the new data.
- R7: A single flipped bit anywhere in a stored 72-bit codeword, check bits and bit 0 included, is corrected before the merge, and `err_dbl` stays 0.
- R8: Two flipped bits in a lane with a clear enable make `err_dbl` pulse with that write. The stored bytes are then taken uncorrected from the read word. A double error in a fully enabled lane does not raise the flag.
- R9: Writes that need no read are accepted on consecutive cycles with `wr_ready` held at 1, and produce one memory write each.
- R10: `mem_rd_valid` while no read-merge-write is pending causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | 1 encodes, 0 bypasses |
| wr_valid | input | 1 | Local write request |
| wr_ready | output | 1 | Local port can accept a write |
| wr_addr | input | ADDR_W | Local write address |
| wr_data | input | LANES*64 | Local write data |
| wr_be | input | LANES*8 | Byte enables, 1 = write byte |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | LANES*72 | Memory write codewords |
| mem_rd_req | output | 1 | Memory read request for a merge |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | LANES*72 | Read codewords |
| err_dbl | output | 1 | Uncorrectable error seen in a merged lane, pulses with the write |

## Verification
The hardest cases to reach are a partial write whose stored codeword is damaged, and a damaged lane sitting next to a merged lane. A correct controller never returns a damaged word. The bench's memory responder therefore keeps a per-address flip mask that it XORs into the returned read data, so single and double errors can be placed at chosen bit positions, including bit 0 and the check positions. The damaged lane can also be fully enabled while the other lane is partial. Reads that arrive while nothing is pending are injected on purpose, to show they are ignored.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CODE_W = 72;
  localparam int SYN_W  = 7;
  localparam int BYTES  = DATA_W / 8;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} wr_state_e;

  // place data bits on non-power-of-two positions, check positions left zero
  function automatic logic [CODE_W-1:0] scatter(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r[p] = d[j];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] gather(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r[j] = c[p];
        j++;
      end
    end
    return r;
  endfunction

  // XOR of the positions of all set bits in 1..CODE_W-1
  function automatic logic [SYN_W-1:0] syndrome(input logic [CODE_W-1:0] c);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (c[p]) s = s ^ SYN_W'(p);
    end
    return s;
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] c;
  logic [SYN_W-1:0]  s;

  always_comb begin
    c = scatter(data);
    s = syndrome(c);
    for (int k = 0; k < SYN_W; k++) begin
      c[1 << k] = s[k];
    end
    c[0] = ^c[CODE_W-1:1];
    code = c;
  end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              dbl
);
  logic [SYN_W-1:0]  s;
  logic              par;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    s     = syndrome(code);
    par   = ^code;
    fixed = code;
    dbl   = 1'b0;
    if (par) begin
      // odd parity: one flipped bit, located by the syndrome
      if (int'(s) < CODE_W) fixed[s] = ~fixed[s];
      else                  dbl      = 1'b1;
    end else if (s != '0) begin
      dbl = 1'b1;
    end
    data = gather(fixed);
  end
endmodule

// File: rtl/ecc_lane.sv
module ecc_lane
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] live_data,
  input  logic [DATA_W-1:0] held_data,
  input  logic [BYTES-1:0]  held_be,
  input  logic [CODE_W-1:0] rd_code,
  output logic [CODE_W-1:0] full_code,
  output logic [CODE_W-1:0] merged_code,
  output logic              dbl_hit
);
  logic [DATA_W-1:0] old_data;
  logic [DATA_W-1:0] merged;
  logic              rd_dbl;

  secded_encoder u_enc_full (.data(live_data), .code(full_code));

  secded_corrector u_fix (.code(rd_code), .data(old_data), .dbl(rd_dbl));

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = held_be[b] ? held_data[b*8 +: 8] : old_data[b*8 +: 8];
  end

  secded_encoder u_enc_merge (.data(merged), .code(merged_code));

  // only a lane that keeps stored bytes depends on the damaged word
  assign dbl_hit = rd_dbl & ~(&held_be);
endmodule

// File: rtl/secded_write_merge.sv
module secded_write_merge
  import secded_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ecc_en,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [LANES*DATA_W-1:0]    wr_data,
  input  logic [LANES*BYTES-1:0]     wr_be,
  output logic                       mem_wr_valid,
  output logic [ADDR_W-1:0]          mem_wr_addr,
  output logic [LANES*CODE_W-1:0]    mem_wr_data,
  output logic                       mem_rd_req,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic                       mem_rd_valid,
  input  logic [LANES*CODE_W-1:0]    mem_rd_data,
  output logic                       err_dbl
);
  localparam int DW = LANES * DATA_W;
  localparam int MW = LANES * CODE_W;
  localparam int BW = LANES * BYTES;

  wr_state_e         state;
  logic [ADDR_W-1:0] hold_addr;
  logic [DW-1:0]     hold_data;
  logic [BW-1:0]     hold_be;
  logic [MW-1:0]     full_word;
  logic [MW-1:0]     merged_word;
  logic [MW-1:0]     bypass_word;
  logic [LANES-1:0]  dbl_vec;
  logic              accept;
  logic              needs_rmw;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecc_lane u_lane (
      .live_data   (wr_data[l*DATA_W +: DATA_W]),
      .held_data   (hold_data[l*DATA_W +: DATA_W]),
      .held_be     (hold_be[l*BYTES +: BYTES]),
      .rd_code     (mem_rd_data[l*CODE_W +: CODE_W]),
      .full_code   (full_word[l*CODE_W +: CODE_W]),
      .merged_code (merged_word[l*CODE_W +: CODE_W]),
      .dbl_hit     (dbl_vec[l])
    );
    assign bypass_word[l*CODE_W +: CODE_W] =
      {{(CODE_W-DATA_W){1'b0}}, wr_data[l*DATA_W +: DATA_W]};
  end

  assign wr_ready  = (state == ST_IDLE);
  assign accept    = wr_valid & wr_ready;
  assign needs_rmw = ecc_en & ~(&wr_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      hold_addr    <= '0;
      hold_data    <= '0;
      hold_be      <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      err_dbl      <= 1'b0;
    end else begin
      mem_wr_valid <= 1'b0;
      mem_rd_req   <= 1'b0;
      err_dbl      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (needs_rmw) begin
              hold_addr   <= wr_addr;
              hold_data   <= wr_data;
              hold_be     <= wr_be;
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= wr_addr;
              state       <= ST_WAIT;
            end else begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= wr_addr;
              mem_wr_data  <= ecc_en ? full_word : bypass_word;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rd_valid) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= hold_addr;
            mem_wr_data  <= merged_word;
            err_dbl      <= |dbl_vec;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/secded_write_merge_chk.sv
module secded_write_merge_chk #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ecc_en,
  input logic                  wr_valid,
  input logic                  wr_ready,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [LANES*64-1:0]   wr_data,
  input logic [LANES*8-1:0]    wr_be,
  input logic                  mem_wr_valid,
  input logic [ADDR_W-1:0]     mem_wr_addr,
  input logic [LANES*72-1:0]   mem_wr_data,
  input logic                  mem_rd_req,
  input logic [ADDR_W-1:0]     mem_rd_addr,
  input logic                  mem_rd_valid,
  input logic                  err_dbl
);
  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && ecc_en && (&wr_be)) |=>
      (mem_wr_valid && !mem_rd_req && mem_wr_addr == $past(wr_addr)));

  a_r4_bypass_direct: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && !ecc_en) |=>
      (mem_wr_valid && !mem_rd_req && mem_wr_data[63:0] == $past(wr_data[63:0])
       && mem_wr_data[71:64] == 8'h00));

  a_r5_partial_read: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && ecc_en && !(&wr_be)) |=>
      (mem_rd_req && !mem_wr_valid && !wr_ready && mem_rd_addr == $past(wr_addr)));

  a_r5_read_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  a_r5_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !wr_ready);

  a_r6_writeback: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && mem_rd_valid) |=> (mem_wr_valid && wr_ready));

  a_r8_flag_with_write: assert property (@(posedge clk) disable iff (rst)
    err_dbl |-> mem_wr_valid);

  a_r10_stray_read: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid && mem_rd_valid) |=> !mem_wr_valid);
endmodule

bind secded_write_merge secded_write_merge_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ecc_en(ecc_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .mem_wr_valid(mem_wr_valid),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .err_dbl(err_dbl)
);

// File: tb/secded_write_merge_test.sv
`timescale 1ns/1ps
module secded_write_merge_test;
  localparam int LANES = 2;
  localparam int AW    = 8;
  localparam int DW    = LANES * 64;
  localparam int MW    = LANES * 72;
  localparam int BW    = LANES * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ecc_en = 1'b1;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [BW-1:0] wr_be = '0;
  logic mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [MW-1:0] mem_wr_data;
  logic mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [MW-1:0] mem_rd_data = '0;
  logic err_dbl;

  always #4 clk = ~clk;

  secded_write_merge #(.LANES(LANES), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .err_dbl(err_dbl)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  logic stray = 1'b0;
  logic [MW-1:0] shadow [256];
  logic [MW-1:0] mem_img [256];
  logic [MW-1:0] flip [256];
  logic [AW+MW:0] exp_q [$];
  string tag_q [$];

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] b_enc(input logic [63:0] d);
    logic [71:0] w;
    logic b;
    int n;
    w = '0;
    n = 0;
    for (int p = 1; p < 72; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        w[p] = d[n];
        n++;
      end
    end
    for (int k = 0; k < 7; k++) begin
      b = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) b = b ^ w[p];
      w[1 << k] = b;
    end
    w[0] = ^w;
    return w;
  endfunction

  function automatic logic [63:0] b_gat(input logic [71:0] w);
    logic [63:0] d;
    int n;
    d = '0;
    n = 0;
    for (int p = 1; p < 72; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        d[n] = w[p];
        n++;
      end
    end
    return d;
  endfunction

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] r;
    for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // driver: computes the expected memory write and pushes it to the scoreboard
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be,
                    input logic en, input string tag);
    logic [MW-1:0] e;
    logic dbl, partial;
    logic [7:0] lb;
    logic [71:0] st, fl;
    logic [63:0] nd, od, md;
    partial = en && !(&be);
    dbl = 1'b0;
    e = '0;
    for (int l = 0; l < LANES; l++) begin
      lb = be[l*8 +: 8];
      st = shadow[a][l*72 +: 72];
      fl = flip[a][l*72 +: 72];
      nd = d[l*64 +: 64];
      if (!en) e[l*72 +: 72] = {8'h00, nd};
      else if (!partial || lb == 8'hFF) e[l*72 +: 72] = b_enc(nd);
      else begin
        if ($countones(fl) >= 2) begin
          od = b_gat(st ^ fl);
          dbl = 1'b1;
        end else od = b_gat(st);
        for (int b = 0; b < 8; b++) md[b*8 +: 8] = lb[b] ? nd[b*8 +: 8] : od[b*8 +: 8];
        e[l*72 +: 72] = b_enc(md);
      end
    end
    exp_q.push_back({a, e, dbl});
    tag_q.push_back(tag);
    shadow[a] = e;
    while (!wr_ready) @(negedge clk);
    ecc_en = en; wr_addr = a; wr_data = d; wr_be = be; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    if (partial) begin
      chk("R5", {mem_rd_req, wr_ready, mem_rd_addr}, {1'b1, 1'b0, a});
      while (!wr_ready) @(negedge clk);
    end
  endtask

  // memory responder: answers reads two cycles later, applying the flip mask
  int pend = 0;
  logic [AW-1:0] pend_addr;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (stray) begin
      mem_rd_valid = 1'b1;
      mem_rd_data = {MW{1'b1}};
      stray = 1'b0;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data = mem_img[pend_addr] ^ flip[pend_addr];
      end
    end
    if (mem_rd_req) begin
      pend = 2;
      pend_addr = mem_rd_addr;
      rd_cnt++;
    end
    if (mem_wr_valid) mem_img[mem_wr_addr] = mem_wr_data;
  end

  // monitor: pops and compares each memory write
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_valid) begin
        if (exp_q.size() == 0) chk("R10", {mem_wr_valid, mem_wr_addr}, '0);
        else begin
          logic [AW+MW:0] x;
          string t;
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {mem_wr_addr, mem_wr_data, err_dbl}, x);
        end
      end else if (err_dbl) chk("R8", 160'(err_dbl), 160'(0));
    end
  end

  logic done = 1'b0;
  initial begin
    #(8ns * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r0;
    logic [DW-1:0] d;
    for (int i = 0; i < 256; i++) begin
      shadow[i] = '0; mem_img[i] = '0; flip[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1", {wr_ready, mem_wr_valid, mem_rd_req, err_dbl}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {wr_ready, mem_wr_valid, mem_rd_req, err_dbl}, 4'b1000);

    // R2 full writes, including zero and all-ones data; R3 lanes differ
    wr(8'd0, '0, '1, 1'b1, "R2");
    wr(8'd1, '1, '1, 1'b1, "R2");
    for (int i = 2; i < 8; i++) wr(AW'(i), rnd(), '1, 1'b1, "R3");

    // R9 back-to-back full writes
    for (int i = 8; i < 14; i++) begin
      chk("R9", 160'(wr_ready), 160'(1));
      wr(AW'(i), rnd(), '1, 1'b1, "R9");
    end

    // R4 bypass, byte enables ignored, no read
    r0 = rd_cnt;
    wr(8'd40, rnd(), 16'h0F0F, 1'b0, "R4");
    wr(8'd41, rnd(), 16'h0000, 1'b0, "R4");
    wr(8'd42, rnd(), '1, 1'b0, "R4");
    @(negedge clk);
    chk("R4", 160'(rd_cnt - r0), 160'(0));

    // R6 merges with clean stored data, various enable patterns
    wr(8'd2, rnd(), 16'h0001, 1'b1, "R6");
    wr(8'd3, rnd(), 16'hAA55, 1'b1, "R6");
    wr(8'd4, rnd(), 16'hFF00, 1'b1, "R3");
    wr(8'd5, rnd(), 16'h0000, 1'b1, "R6");
    wr(8'd60, rnd(), 16'h8001, 1'b1, "R6");

    // R7 single-bit errors at many positions, both lanes
    foreach (r7_pos[i]) begin
      flip[6] = '0;
      flip[6][r7_pos[i]] = 1'b1;
      wr(8'd6, rnd(), 16'h3C3C, 1'b1, "R7");
      flip[6] = '0;
    end

    // R8 double errors: merged lane flags, fully enabled lane does not
    flip[7] = '0; flip[7][5] = 1'b1; flip[7][40] = 1'b1;
    wr(8'd7, rnd(), 16'hFF0F, 1'b1, "R8");
    flip[7] = '0;
    flip[8] = '0; flip[8][0] = 1'b1; flip[8][70] = 1'b1;
    wr(8'd8, rnd(), 16'hF0FF, 1'b1, "R8");
    flip[8] = '0;
    flip[9] = '0; flip[9][72+3] = 1'b1; flip[9][72+60] = 1'b1;
    wr(8'd9, rnd(), 16'hFF01, 1'b1, "R8");
    flip[9] = '0;
    wr(8'd9, rnd(), 16'h00FF, 1'b1, "R6");

    // R10 stray read data while idle
    stray = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", {wr_ready, mem_wr_valid}, 2'b10);
    end

    d = rnd();
    wr(8'd10, d, 16'h1234, 1'b1, "R6");
    repeat (4) @(negedge clk);
    chk("R6", 160'(exp_q.size()), 160'(0));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int r7_pos [8] = '{0, 1, 3, 32, 64, 71, 72 + 0, 72 + 50};
endmodule